// File: doc/BRIEF.md
# Floating-Point Adder with Leading-Zero Anticipation

This block adds or subtracts two single-precision binary floating-point numbers with normal encodings and returns the rounded single-precision result one clock after a valid input. The operand with the smaller magnitude is shifted right to line up with the larger one. Shifted-out bits are kept as guard, round and sticky bits. The aligned significands are then added, or the smaller is subtracted from the larger.

When the operation cancels leading bits, the normalization shift is not found by scanning the finished difference. An anticipator works from the two aligned significands in parallel with the subtractor and marks the digit where the leading one will land. Its guess is never too large and at most one position too small. A single two-way multiplexer fixes the final position. Rounding is round-to-nearest with ties to even.

The block accepts one operation per cycle. It expects operands and results whose exponents stay inside the normal range. Denormals, infinities, NaNs and exception flags are not handled.

Top module: `fpaddLza`

## Requirements
- R1: One rising clock edge after a cycle with `inValid` high, `outValid` is high and `result` holds the sum or difference of the operands from that cycle. In every other cycle `outValid` is low.
- R2: After a cycle with `inValid` low, `result` keeps its previous value, whatever the operand inputs carry.
- R3: The effective sign of the second operand is `opB[31]` XOR `subOp`, where `subOp` = 1 requests `opA - opB`. When this effective sign equals `opA[31]`, the magnitudes are added and the result carries that sign. A carry out of the significand raises the exponent by one.
- R4: When the effective signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger-magnitude operand.
- R5: The smaller operand is aligned by the exponent difference. Bits shifted out beyond the round position survive only as a sticky indication, so a difference of 26 or more cannot change the larger operand except through rounding.
- R6: In a subtraction with a nonzero difference, the predicted normalization shift makes the top bit or the next bit of the difference the leading one, and it never shifts a set bit out. The final result is normalized with its exponent reduced by the corrected shift. This holds when the exponents are equal or differ by one, including cancellation of 20 or more bits.
- R7: Rounding is to nearest. An exact halfway case rounds to the even significand: 1.0 + 2^-24 gives 0x3F800000.
- R8: A rounding carry out of the significand renormalizes the result and raises the exponent by one: 0x3FFFFFFF + 0x33800000 gives 0x40000000.
- R9: An exact zero difference gives +0 (0x00000000), whatever the operand signs.
- R10: While `rst_n` is low, `outValid` is low and `result` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and operation are present this cycle |
| opA | input | 32 | First operand, single precision |
| opB | input | 32 | Second operand, single precision |
| subOp | input | 1 | 1: opA - opB, 0: opA + opB |
| outValid | output | 1 | Result register updated on the last edge |
| result | output | 32 | Rounded single-precision result |

## Verification
The bench goes after the cases where the anticipator is off by one: close operands with equal exponents or exponents one apart, where heavy cancellation makes a shift that is short by one, or that has the wrong indicator term, show up as a result with a zero leading bit or an exponent off by one. It tries exact ties both ways and an all-ones significand that carries out while rounding. A broken tie rule or a missing renormalization gives an odd last bit, or an exponent that is one too low with the significand wrapped to zero. Large alignment distances and exact cancellation are also covered. A lost sticky bit would round the wrong way, and a zero result that takes an operand's sign would come out as -0 instead of +0.

// File: rtl/fpaddLzaPkg.sv
package fpaddLzaPkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int MANT_W = FRAC_W + 1;        // hidden one + fraction
  localparam int EXT_W  = MANT_W + 3;        // plus guard, round, sticky
  localparam int LZ_W   = $clog2(EXT_W);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  typedef struct packed {
    logic load;   // capture the computed result
  } fpaStrobe_t;
endpackage

// File: rtl/fpaddLzaAnticipator.sv
// Predicts the leading-one position of x - y (x >= y) from digit patterns.
// Digit d_i = x_i - y_i in {-1,0,+1}; leading one is at the end of the
// first "+1 (-1)*" run, or one place below it.
module fpaddLzaAnticipator #(
  parameter int W    = 27,
  parameter int LZ_W = 5
) (
  input  logic [W-1:0]    x,
  input  logic [W-1:0]    y,
  output logic [LZ_W-1:0] lzPred
);
  logic [W-1:0] gen, kil, eqv, ind;

  assign gen = x & ~y;
  assign kil = ~x & y;
  assign eqv = ~(x ^ y);

  for (genvar i = 0; i < W; i++) begin : gInd
    logic kilBelow, eqAbove;
    if (i == 0) begin : gLo
      assign kilBelow = 1'b0;
    end else begin : gMid
      assign kilBelow = kil[i-1];
    end
    if (i == W - 1) begin : gHi
      assign eqAbove = 1'b1;
    end else begin : gMidHi
      assign eqAbove = eqv[i+1];
    end
    assign ind[i] = ~kilBelow & (gen[i] | (kil[i] & ~eqAbove));
  end

  always_comb begin
    lzPred = '0;
    for (int i = 0; i < W; i++) begin
      if (ind[i]) lzPred = LZ_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpaddLzaCtrl.sv
module fpaddLzaCtrl
  import fpaddLzaPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output fpaStrobe_t strobes,
  output logic       outValid
);
  assign strobes.load = inValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/fpaddLzaDatapath.sv
module fpaddLzaDatapath
  import fpaddLzaPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fpaStrobe_t        strobes,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subOp,
  output logic [WORD_W-1:0] result
);
  localparam int WIDE_W = MANT_W + EXT_W - 1;
  localparam int XE_W   = EXP_W + 2;

  logic              bSign, swap, bigSign, effSub;
  logic [EXP_W-1:0]  bigExp, smlExp, expDiff;
  logic [MANT_W-1:0] bigMant, smlMant;
  logic [WIDE_W-1:0] wideSml;
  logic [EXT_W-1:0]  xAl, yAl, diffVal, preShift, corrected, norm;
  logic [EXT_W:0]    sumVal;
  logic [LZ_W-1:0]   lzPred;
  logic [LZ_W:0]     lzTot;
  logic [XE_W-1:0]   expNorm, expOut;
  logic [MANT_W:0]   rnd;
  logic              roundUp, isZero;
  logic [WORD_W-1:0] nextResult;

  // operand ordering by magnitude
  assign bSign   = opB[WORD_W-1] ^ subOp;
  assign swap    = opB[WORD_W-2:0] > opA[WORD_W-2:0];
  assign bigSign = swap ? bSign : opA[WORD_W-1];
  assign effSub  = opA[WORD_W-1] ^ bSign;
  assign bigExp  = swap ? opB[WORD_W-2 -: EXP_W] : opA[WORD_W-2 -: EXP_W];
  assign smlExp  = swap ? opA[WORD_W-2 -: EXP_W] : opB[WORD_W-2 -: EXP_W];
  assign bigMant = {1'b1, swap ? opB[FRAC_W-1:0] : opA[FRAC_W-1:0]};
  assign smlMant = {1'b1, swap ? opA[FRAC_W-1:0] : opB[FRAC_W-1:0]};
  assign expDiff = bigExp - smlExp;

  // alignment: far shifts collapse into the sticky bit
  always_comb begin
    wideSml = {smlMant, {(EXT_W-1){1'b0}}};
    if (expDiff >= EXP_W'(EXT_W)) wideSml = wideSml >> EXT_W;
    else                         wideSml = wideSml >> expDiff;
  end
  assign xAl = {bigMant, 3'b000};
  assign yAl = {wideSml[WIDE_W-1 -: EXT_W-1], |wideSml[WIDE_W-EXT_W:0]};

  assign sumVal  = {1'b0, xAl} + {1'b0, yAl};
  assign diffVal = xAl - yAl;

  fpaddLzaAnticipator #(.W(EXT_W), .LZ_W(LZ_W)) uLza (
    .x(xAl), .y(yAl), .lzPred(lzPred)
  );

  // one-position fix-up instead of a full count-and-shift
  assign preShift  = diffVal << lzPred;
  assign corrected = preShift[EXT_W-1] ? preShift : (preShift << 1);
  assign lzTot     = {1'b0, lzPred} + (LZ_W+1)'(!preShift[EXT_W-1]);

  always_comb begin
    if (effSub) begin
      norm    = corrected;
      expNorm = XE_W'(bigExp) - XE_W'(lzTot);
    end else if (sumVal[EXT_W]) begin
      norm    = {sumVal[EXT_W:2], |sumVal[1:0]};
      expNorm = XE_W'(bigExp) + XE_W'(1);
    end else begin
      norm    = sumVal[EXT_W-1:0];
      expNorm = XE_W'(bigExp);
    end
  end

  // round to nearest, ties to even
  assign roundUp = norm[2] & (norm[3] | norm[1] | norm[0]);
  assign rnd     = {1'b0, norm[EXT_W-1:3]} + (MANT_W+1)'(roundUp);
  assign expOut  = expNorm + XE_W'(rnd[MANT_W]);
  assign isZero  = effSub && (diffVal == '0);

  always_comb begin
    if (isZero)            nextResult = '0;
    else if (rnd[MANT_W])  nextResult = {bigSign, expOut[EXP_W-1:0], {FRAC_W{1'b0}}};
    else                   nextResult = {bigSign, expOut[EXP_W-1:0], rnd[FRAC_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            result <= '0;
    else if (strobes.load) result <= nextResult;
  end
endmodule

// File: rtl/fpaddLza.sv
module fpaddLza
  import fpaddLzaPkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        subOp,
  output logic        outValid,
  output logic [31:0] result
);
  fpaStrobe_t strobes;

  fpaddLzaCtrl uCtrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .strobes(strobes), .outValid(outValid)
  );

  fpaddLzaDatapath uDp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .opA(opA), .opB(opB), .subOp(subOp), .result(result)
  );
endmodule

// File: rtl/fpaddLzaChk.sv
module fpaddLzaChk
  import fpaddLzaPkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic [31:0]      opA,
  input logic [31:0]      opB,
  input logic             subOp,
  input logic             outValid,
  input logic [31:0]      result,
  input logic             isSub,
  input logic [EXT_W-1:0] diffVal,
  input logic [LZ_W-1:0]  lzPred
);
  logic [EXT_W-1:0] predShifted, lostBits;
  logic             sameSign;

  assign predShifted = diffVal << lzPred;
  assign lostBits    = diffVal >> (EXT_W - int'(lzPred));
  assign sameSign    = opA[31] == (opB[31] ^ subOp);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid == $past(inValid));

  // R2
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(result));

  // R3
  add_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && sameSign) |=> result[31] == $past(opA[31]));

  // R6
  lza_not_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && isSub && diffVal != '0) |-> (predShifted[EXT_W-1] || predShifted[EXT_W-2]));

  // R6
  lza_no_overshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && isSub) |-> lostBits == '0);

  // R9
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && isSub && diffVal == '0) |=> result == 32'h0);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!outValid && result == 32'h0));
endmodule

bind fpaddLza fpaddLzaChk uChk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .opB(opB),
  .subOp(subOp), .outValid(outValid), .result(result),
  .isSub(uDp.effSub), .diffVal(uDp.diffVal), .lzPred(uDp.lzPred)
);

// File: tb/fpaddLza_test.sv
`timescale 1ns/1ps
module fpaddLza_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        subOp = 1'b0;
  logic        outValid;
  logic [31:0] result;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fpaddLza uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .opB(opB),
    .subOp(subOp), .outValid(outValid), .result(result)
  );

  // exact reference: scale both significands to a common wide grid
  function automatic logic [31:0] refAdd(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic [299:0] va, vb, mag, mask;
    logic sa, sb, sr;
    int ea, eb, emin, p, sh, er;
    logic [24:0] keep;
    logic g, st;
    sa = a[31]; sb = b[31] ^ s;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    emin = (ea < eb) ? ea : eb;
    va = 300'({1'b1, a[22:0]}) << (ea - emin);
    vb = 300'({1'b1, b[22:0]}) << (eb - emin);
    if (sa == sb) begin mag = va + vb; sr = sa; end
    else if (va >= vb) begin mag = va - vb; sr = sa; end
    else begin mag = vb - va; sr = sb; end
    if (mag == '0) return 32'h0;
    p = 0;
    for (int i = 0; i < 300; i++) if (mag[i]) p = i;
    er = emin + p - 23;
    if (p > 23) begin
      sh = p - 23;
      keep = 25'(mag >> sh);
      g = mag[sh-1];
      mask = (300'(1) << (sh - 1)) - 300'(1);
      st = |(mag & mask);
      if (g && (st || keep[0])) keep = keep + 25'd1;
      if (keep[24]) begin keep = keep >> 1; er = er + 1; end
    end else begin
      keep = 25'(mag << (23 - p));
    end
    return {sr, 8'(er), keep[22:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic s, input string req);
    logic [31:0] held;
    @(negedge clk);
    opA = a; opB = b; subOp = s; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R1 valid"}, {31'b0, outValid}, 32'd1);
    check(req, result, refAdd(a, b, s));
    held = result;
    opA = ~a; opB = b ^ 32'h0055_5555; subOp = ~s;
    @(negedge clk);
    if (($urandom % 8) == 0) begin
      check("R2 hold", result, held);
      check("R1 idle valid", {31'b0, outValid}, 32'd0);
    end
  endtask

  function automatic logic [31:0] mkNum(input logic sg, input int e, input logic [22:0] f);
    return {sg, 8'(e), f};
  endfunction

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    check("R10 reset result", result, 32'h0);
    check("R10 reset valid", {31'b0, outValid}, 32'd0);
    rst_n = 1'b1;

    // directed corners
    runOp(32'h3f800000, 32'h3f800000, 1'b0, "R3 carry");
    check("R3 1+1", result, 32'h40000000);
    runOp(32'h3f800000, 32'h33800000, 1'b0, "R7 tie even");
    check("R7 tie down", result, 32'h3f800000);
    runOp(32'h3fffffff, 32'h33800000, 1'b0, "R8 round carry");
    check("R8 exp bump", result, 32'h40000000);
    runOp(32'h3f800000, 32'h21800000, 1'b0, "R5 far align");
    check("R5 absorbed", result, 32'h3f800000);
    runOp(32'h40490fdb, 32'h40490fdb, 1'b1, "R9 x-x");
    check("R9 plus zero", result, 32'h0);
    runOp(32'hc0490fdb, 32'h40490fdb, 1'b0, "R9 neg sum");
    check("R9 plus zero neg", result, 32'h0);
    runOp(32'h3f800001, 32'h3f800000, 1'b1, "R6 deep cancel");
    check("R6 deep", result, 32'h34000000);
    runOp(32'h3f800000, 32'h3f7fffff, 1'b1, "R6 diff one exp");
    check("R6 exp1", result, 32'h33800000);
    runOp(32'h3f800000, 32'h40000000, 1'b1, "R4 sign larger");
    check("R4 1-2", result, 32'hbf800000);

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] a, b;
      int ea, eb, mode;
      logic s;
      mode = int'($urandom % 4);
      ea = 60 + int'($urandom % 130);
      a = mkNum(1'($urandom), ea, 23'($urandom));
      s = 1'($urandom);
      case (mode)
        0: eb = 60 + int'($urandom % 130);
        1: eb = ea;
        2: eb = ea - 1 + int'($urandom % 3);
        default: eb = ea + int'($urandom % 40) - 20;
      endcase
      if (mode == 1 && ($urandom % 2) == 1)
        b = {1'($urandom), a[30:0] ^ (32'($urandom) & 32'h0000_00ff)};
      else
        b = mkNum(1'($urandom), eb, 23'($urandom));
      case (mode)
        0: runOp(a, b, s, "R5 random");
        1: runOp(a, b, s, "R6 equal exp");
        2: runOp(a, b, s, "R6 near exp");
        default: runOp(a, b, s, (a[31] == (b[31] ^ s)) ? "R3 random" : "R4 random");
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule